// File: doc/BRIEF.md
# Buffered SPI Burst Host

This block is an SPI host that moves a whole burst of bytes in one go. Software first fills a local command buffer through a byte write port. It then writes a single control word that holds the byte count, the SCK divider, the clock mode and a go bit. The engine shifts the buffered bytes out MSB first on `mosi`. At the same time it collects the bytes that return on `miso` into a response buffer, which software reads back through a byte read port.

The end of a burst is reported by a sticky done flag in an event word. Software clears that flag by writing a 1 to its bit. While a burst runs, the control fields and the command buffer are frozen. This lets software prepare the control word with read-modify-write without disturbing a transfer in flight.

The buffer ports are plain addressed memory ports with no handshake. A command write is taken on the clock edge where `cmd_we` is high. Response data appears on `rsp_rdata` one clock after `rsp_addr` is presented. Neither port can stall, so there is no back-pressure.

Top module: `spi_burst_host`

## Requirements
- R1: Writing the control word with bit 0 (go) set while idle launches a burst. Control bit 0 reads 1 while the burst runs and reads 0 again once it has finished.
- R2: Control bit 2 selects the clock mode: 0 means SCK idles low, 1 means SCK idles high. In both modes `miso` is sampled on the rising SCK edge, and a burst of N bytes makes exactly 8*N rising SCK edges.
- R3: Control bits [7:5] hold the divider D. Each SCK half-period lasts D+1 clocks, so a burst of N bytes takes N*16*(D+1) clocks from the launch edge to the edge that sets done.
- R4: Control bits [16:8] hold the byte count N. The host sends command buffer bytes 0 to N-1 in index order, each MSB first.
- R5: The byte received during byte slot i, assembled MSB first, is stored at response buffer index i. It reads back on `rsp_rdata` one clock after `rsp_addr` is set to i.
- R6: Event bit 8 (done) is set on the same edge that clears control bit 0. It stays set until software clears it.
- R7: A write to the event word clears bit 8 only when that bit of the written data is 1. A 0 in bit 8 leaves the flag unchanged.
- R8: While a burst runs, control writes and command buffer writes are ignored. The control fields read back unchanged, and the bytes already in the buffer are the ones sent.
- R9: A launch with byte count 0 sets done on the launch edge, leaves control bit 0 at 0 and makes no SCK edge.
- R10: A byte count above the buffer depth (320) is stored and used as 320.
- R11: After reset the control and event words read 0, and `sck` and `mosi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback (bit 0 shows busy) |
| evt_we | input | 1 | Event word write strobe (write 1 to clear) |
| evt_wdata | input | 32 | Event word write data |
| evt_rdata | output | 32 | Event word, bit 8 is done |
| cmd_we | input | 1 | Command buffer byte write strobe |
| cmd_addr | input | AW (9) | Command buffer byte index |
| cmd_wdata | input | 8 | Command byte to store |
| rsp_addr | input | AW (9) | Response buffer byte index |
| rsp_rdata | output | 8 | Response byte, registered one clock after the address |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out of the host |
| miso | input | 1 | Serial data into the host |

## Verification
Several kinds of internal fault show up at the ports in recognisable ways. A wrong half-period counter shows up within the first byte: the clock count from launch to done is off by a multiple of 16. A byte index or bit counter that slips corrupts the captured `mosi` stream and the response buffer from the first affected byte on, and the rising SCK edge count for the burst goes wrong with it. A faulty busy gate or a wrong event-clear path shows up at once. The control readback taken during the burst would change, or the done flag would drop on a write that carries 0 in bit 8.

// File: rtl/sbh_pkg.sv
`timescale 1ns/1ps
package sbh_pkg;
  // Control word bit positions (software decodes these)
  localparam int CTL_GO_BIT   = 0;
  localparam int CTL_MODE_BIT = 2;
  localparam int CTL_DIV_LSB  = 5;
  localparam int CTL_LEN_LSB  = 8;
  // Event word bit positions
  localparam int EVT_DONE_BIT = 8;
endpackage

// File: rtl/sbh_ctl_regs.sv
`timescale 1ns/1ps
module sbh_ctl_regs
  import sbh_pkg::*;
#(
  parameter int DEPTH = 320,
  parameter int DIV_W = 3,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  input  logic             evt_we,
  input  logic [31:0]      evt_wdata,
  input  logic             eng_busy,
  input  logic             eng_end,
  output logic             start,
  output logic [LEN_W-1:0] start_len,
  output logic [DIV_W-1:0] start_div,
  output logic             mode_q,
  output logic [31:0]      ctl_rdata,
  output logic [31:0]      evt_rdata
);
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_raw;
  logic             accept, launch, zero_done, done_q;

  assign len_raw   = ctl_wdata[CTL_LEN_LSB +: LEN_W];
  assign start_len = (len_raw > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : len_raw;
  assign start_div = ctl_wdata[CTL_DIV_LSB +: DIV_W];
  assign accept    = ctl_we && !eng_busy;
  assign launch    = accept && ctl_wdata[CTL_GO_BIT];
  assign start     = launch && (start_len != '0);
  assign zero_done = launch && (start_len == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      div_q  <= '0;
      len_q  <= '0;
    end else if (accept) begin
      mode_q <= ctl_wdata[CTL_MODE_BIT];
      div_q  <= start_div;
      len_q  <= start_len;
    end
  end

  // Sticky done: a new completion wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 done_q <= 1'b0;
    else if (eng_end || zero_done)              done_q <= 1'b1;
    else if (evt_we && evt_wdata[EVT_DONE_BIT]) done_q <= 1'b0;
  end

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[CTL_GO_BIT]              = eng_busy;
    ctl_rdata[CTL_MODE_BIT]            = mode_q;
    ctl_rdata[CTL_DIV_LSB +: DIV_W]    = div_q;
    ctl_rdata[CTL_LEN_LSB +: LEN_W]    = len_q;
    evt_rdata = '0;
    evt_rdata[EVT_DONE_BIT]            = done_q;
  end
endmodule

// File: rtl/sbh_byte_bufs.sv
`timescale 1ns/1ps
module sbh_byte_bufs #(
  parameter int DEPTH = 320,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_waddr,
  input  logic [7:0]    cmd_wdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [7:0]    eng_rdata,
  input  logic          rsp_we,
  input  logic [AW-1:0] rsp_widx,
  input  logic [7:0]    rsp_wbyte,
  input  logic [AW-1:0] rsp_raddr,
  output logic [7:0]    rsp_rdata
);
  logic [7:0] cmd_mem [DEPTH];
  logic [7:0] rsp_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cmd_we && (32'(cmd_waddr) < DEPTH)) cmd_mem[cmd_waddr] <= cmd_wdata;
    if (rsp_we && (32'(rsp_widx) < DEPTH))  rsp_mem[rsp_widx]  <= rsp_wbyte;
  end

  assign eng_rdata = (32'(eng_raddr) < DEPTH) ? cmd_mem[eng_raddr] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rsp_rdata <= 8'h00;
    else if (32'(rsp_raddr) < DEPTH)   rsp_rdata <= rsp_mem[rsp_raddr];
    else                               rsp_rdata <= 8'h00;
  end
endmodule

// File: rtl/sbh_shift_engine.sv
`timescale 1ns/1ps
module sbh_shift_engine #(
  parameter int AW    = 9,
  parameter int LEN_W = 9,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic [DIV_W-1:0] start_div,
  input  logic [7:0]       cmd_rbyte,
  output logic [AW-1:0]    cmd_raddr,
  input  logic             miso,
  output logic             busy,
  output logic             phase,
  output logic             mosi,
  output logic             rsp_we,
  output logic [AW-1:0]    rsp_widx,
  output logic [7:0]       rsp_wbyte,
  output logic             burst_end
);
  logic [DIV_W-1:0] div_l, hcnt;
  logic [2:0]       bitn;
  logic [AW-1:0]    idx, last;
  logic [7:0]       tx_sh, rx_sh;
  logic             half_end, byte_end;

  // phase 0 = SCK low half, phase 1 = SCK high half; sample at 0->1
  assign half_end  = busy && (hcnt == div_l);
  assign byte_end  = half_end && phase && (bitn == 3'd0);
  assign cmd_raddr = busy ? idx + AW'(1) : '0;
  assign mosi      = busy && tx_sh[7];
  assign rsp_we    = byte_end;
  assign rsp_widx  = idx;
  assign rsp_wbyte = rx_sh;
  assign burst_end = byte_end && (idx == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= 1'b0;
      div_l <= '0;
      hcnt  <= '0;
      bitn  <= 3'd7;
      idx   <= '0;
      last  <= '0;
      tx_sh <= 8'h00;
      rx_sh <= 8'h00;
    end else if (start) begin
      busy  <= 1'b1;
      phase <= 1'b0;
      div_l <= start_div;
      hcnt  <= '0;
      bitn  <= 3'd7;
      idx   <= '0;
      last  <= AW'(start_len - LEN_W'(1));
      tx_sh <= cmd_rbyte;
      rx_sh <= 8'h00;
    end else if (busy) begin
      if (!half_end) begin
        hcnt <= hcnt + DIV_W'(1);
      end else begin
        hcnt <= '0;
        if (!phase) begin
          phase <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          phase <= 1'b0;
          if (bitn != 3'd0) begin
            bitn  <= bitn - 3'd1;
            tx_sh <= {tx_sh[6:0], 1'b0};
          end else if (idx == last) begin
            busy <= 1'b0;
          end else begin
            idx   <= idx + AW'(1);
            bitn  <= 3'd7;
            tx_sh <= cmd_rbyte;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_host.sv
`timescale 1ns/1ps
module spi_burst_host #(
  parameter  int DEPTH = 320,
  parameter  int DIV_W = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_rdata,
  input  logic          evt_we,
  input  logic [31:0]   evt_wdata,
  output logic [31:0]   evt_rdata,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_wdata,
  input  logic [AW-1:0] rsp_addr,
  output logic [7:0]    rsp_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso
);
  logic             eng_busy, eng_end, eng_phase, start, mode_q;
  logic [LEN_W-1:0] start_len;
  logic [DIV_W-1:0] start_div;
  logic [AW-1:0]    cmd_raddr, rsp_widx;
  logic [7:0]       cmd_rbyte, rsp_wbyte;
  logic             rsp_we;

  sbh_ctl_regs #(.DEPTH(DEPTH), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .evt_we(evt_we), .evt_wdata(evt_wdata),
    .eng_busy(eng_busy), .eng_end(eng_end),
    .start(start), .start_len(start_len), .start_div(start_div),
    .mode_q(mode_q), .ctl_rdata(ctl_rdata), .evt_rdata(evt_rdata)
  );

  sbh_byte_bufs #(.DEPTH(DEPTH), .AW(AW)) u_bufs (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we && !eng_busy), .cmd_waddr(cmd_addr), .cmd_wdata(cmd_wdata),
    .eng_raddr(cmd_raddr), .eng_rdata(cmd_rbyte),
    .rsp_we(rsp_we), .rsp_widx(rsp_widx), .rsp_wbyte(rsp_wbyte),
    .rsp_raddr(rsp_addr), .rsp_rdata(rsp_rdata)
  );

  sbh_shift_engine #(.AW(AW), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_len(start_len), .start_div(start_div),
    .cmd_rbyte(cmd_rbyte), .cmd_raddr(cmd_raddr), .miso(miso),
    .busy(eng_busy), .phase(eng_phase), .mosi(mosi),
    .rsp_we(rsp_we), .rsp_widx(rsp_widx), .rsp_wbyte(rsp_wbyte),
    .burst_end(eng_end)
  );

  // Idle level follows the mode bit; during a burst the engine phase drives it
  assign sck = eng_busy ? eng_phase : mode_q;
endmodule

// File: rtl/sbh_chk.sv
`timescale 1ns/1ps
module sbh_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        sck,
  input logic        mosi,
  input logic        evt_we,
  input logic [31:0] evt_wdata,
  input logic [31:0] ctl_rdata,
  input logic [31:0] evt_rdata
);
  // R2: when idle, SCK rests at the level chosen by the mode bit
  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == ctl_rdata[2]));

  // R8: control fields are frozen for the whole burst
  assert_ctl_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctl_rdata[31:1]));

  // R6: done stays set unless cleared
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rdata[8] && !(evt_we && evt_wdata[8])) |=> evt_rdata[8]);

  // R6: done never rises while the go bit still reads 1
  assert_done_after_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_rdata[8]) |-> !ctl_rdata[0]);

  // R4: mosi holds steady through the high half of SCK in a burst
  assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sck && $past(sck)) |-> $stable(mosi));
endmodule

bind spi_burst_host sbh_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .sck(sck), .mosi(mosi),
  .evt_we(evt_we), .evt_wdata(evt_wdata),
  .ctl_rdata(ctl_rdata), .evt_rdata(evt_rdata)
);

// File: tb/sim_spi_burst_host.sv
`timescale 1ns/1ps
module sim_spi_burst_host;
  localparam int DEPTH = 320;
  localparam int AW    = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          ctl_we = 0, evt_we = 0, cmd_we = 0, miso = 0;
  logic [31:0]   ctl_wdata = 0, evt_wdata = 0, ctl_rdata, evt_rdata;
  logic [AW-1:0] cmd_addr = 0, rsp_addr = 0;
  logic [7:0]    cmd_wdata = 0, rsp_rdata;
  logic          sck, mosi;

  spi_burst_host #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .evt_we(evt_we), .evt_wdata(evt_wdata), .evt_rdata(evt_rdata),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] cmd_ref [DEPTH];
  logic [7:0] slv     [DEPTH];
  logic [7:0] cap     [DEPTH];
  int sbits = 0, rises = 0;

  // Slave model: capture mosi and advance miso on each rising SCK edge
  always @(posedge sck) begin
    if (sbits < DEPTH*8) cap[sbits/8][7-(sbits%8)] = mosi;
    sbits++;
    rises++;
    if (sbits < DEPTH*8) miso = slv[sbits/8][7-(sbits%8)];
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] exp_ctl(bit go, bit mode, int div, int len);
    return 32'(go) | (32'(mode) << 2) | (32'(div) << 5) | (32'(len) << 8);
  endfunction

  task automatic launch(logic [31:0] w);
    @(negedge clk); ctl_we = 1; ctl_wdata = w;
    @(posedge clk); #1 ctl_we = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (evt_rdata[8] || n > 100000) break;
      n++;
    end
  endtask

  task automatic evt_write(logic [31:0] w);
    @(negedge clk); evt_we = 1; evt_wdata = w;
    @(negedge clk); evt_we = 0;
  endtask

  task automatic load_and_arm(int eff);
    for (int i = 0; i < eff; i++) begin
      cmd_ref[i] = 8'($urandom);
      slv[i]     = 8'($urandom);
      @(negedge clk); cmd_we = 1; cmd_addr = AW'(i); cmd_wdata = cmd_ref[i];
    end
    @(negedge clk); cmd_we = 0;
    evt_write(32'h100);
    sbits = 0; rises = 0;
    miso = (eff > 0) ? slv[0][7] : 1'b0;
  endtask

  task automatic check_data(int eff);
    int bad_tx = 0, bad_rx = 0;
    for (int i = 0; i < eff; i++) if (cap[i] !== cmd_ref[i]) bad_tx++;
    chk("R4", "mosi byte mismatches", bad_tx, 0);
    for (int i = 0; i < eff; i++) begin
      @(negedge clk); rsp_addr = AW'(i);
      @(negedge clk); if (rsp_rdata !== slv[i]) bad_rx++;
    end
    chk("R5", "response byte mismatches", bad_rx, 0);
  endtask

  task automatic run_burst(int len, int div, bit mode);
    int eff, n;
    eff = (len > DEPTH) ? DEPTH : len;
    load_and_arm(eff);
    launch(exp_ctl(1, mode, div, len));
    wait_done(n);
    chk("R3", "launch-to-done clocks", n, eff*16*(div+1));
    chk("R6", "done flag", evt_rdata[8], 1);
    chk(len > DEPTH ? "R10" : "R1", "control after burst", ctl_rdata, exp_ctl(0, mode, div, eff));
    chk(eff == 0 ? "R9" : "R2", "rising sck edges", rises, eff*8);
    chk("R2", "idle sck level", sck, mode);
    if (eff > 0) check_data(eff);
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    chk("R11", "ctl after reset", ctl_rdata, 0);
    chk("R11", "evt after reset", evt_rdata, 0);
    chk("R11", "sck after reset", sck, 0);
    chk("R11", "mosi after reset", mosi, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Directed corners
    run_burst(1, 0, 0);
    run_burst(3, 7, 1);
    run_burst(0, 2, 1);           // R9 zero length
    run_burst(400, 0, 0);         // R10 clamp

    // R7: event clear rules
    evt_write(32'hFFFF_FEFF);
    chk("R7", "done kept on 0 write", evt_rdata[8], 1);
    repeat (20) @(negedge clk);
    chk("R6", "done still sticky", evt_rdata[8], 1);
    evt_write(32'h0000_0100);
    chk("R7", "done cleared by 1 write", evt_rdata[8], 0);

    // R8: writes during a burst are ignored
    load_and_arm(4);
    launch(exp_ctl(1, 1, 2, 4));
    chk("R1", "go reads 1 while busy", ctl_rdata[0], 1);
    repeat (5) @(negedge clk);
    ctl_we = 1; ctl_wdata = exp_ctl(1, 0, 5, 9);
    cmd_we = 1; cmd_addr = AW'(1); cmd_wdata = ~cmd_ref[1];
    @(negedge clk); ctl_we = 0; cmd_we = 0;
    chk("R8", "control during burst", ctl_rdata, exp_ctl(1, 1, 2, 4));
    wait_done(n);
    chk("R8", "control after ignored write", ctl_rdata, exp_ctl(0, 1, 2, 4));
    chk("R3", "clocks with ignored writes", n + 6, 4*16*3);
    check_data(4);

    // Constrained random bursts
    for (int k = 0; k < 8; k++) begin
      run_burst(1 + int'($urandom_range(11)), int'($urandom_range(7)), 1'($urandom_range(1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule